// File: doc/BRIEF.md
# Link Layer Frame Transmitter

This block is the transmit state machine of a serial storage link. An upper layer offers payload dwords through a FIFO-style pop interface, and each dword comes with an end-of-frame marker. The block turns each payload into a frame and sends it on a transmit channel, one dword or primitive per clock. It reads the primitives that the far end sends back on a receive channel. It makes a ready handshake before the frame, pauses for flow control in both directions, appends a 32-bit CRC, and waits for the far end's reception verdict. It then reports the verdict upward with a single-cycle pulse.

The far end can ask for a frame to stop early. A frame that would exceed the length limit is cut short. In both cases the block closes the frame properly with a CRC and an end marker. After the verdict it discards the unsent rest of that payload, so the next frame starts clean. Both the transmit and receive channels carry a 4-bit kind code. On the transmit side, code 0 means the 32-bit word is payload or CRC data.

Top module: `frame_tx_link`

## Requirements
- R1: With no payload pending, the transmitter outputs the SYNC primitive (kind 1) and never pops.
- R2: With a payload pending, the transmitter outputs X_RDY (kind 2) until R_RDY (kind 3) is received, and outputs SOF (kind 4) in the following cycle.
- R3: After SOF, the payload dwords are output in order as data (kind 0), and each is popped in the cycle it is output.
- R4: If no payload dword is available mid-frame, HOLD (kind 6) is output in its place and nothing is popped.
- R5: While HOLD (kind 6) is received mid-frame, HOLDA (kind 7) is output and nothing is popped. This takes priority over R4.
- R6: After the last payload dword, one data dword carrying the CRC is output, followed by EOF (kind 5). The CRC uses polynomial 0x04C11DB7, most significant bit first with no reflection, and starts from 0x52325032. It covers only the payload dwords actually output.
- R7: When DMAT (kind 8) is received mid-frame, the CRC over the dwords sent so far is output in that same cycle, followed by EOF.
- R8: After EOF, WTRM (kind 9) is output until R_OK (kind 10) or R_ERR (kind 11) is received. In that cycle done pulses and done_ok is 1 only for R_OK.
- R9: A frame carries at most MAX_DW-1 payload dwords. A longer payload is cut after that many dwords and closed with CRC and EOF, and done_trunc is 1 with its done pulse.
- R10: After a frame that ended before its last dword (R7 or R9), the remaining dwords up to and including the marked last one are popped and dropped while SYNC is output. The transmitter then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pl_valid | input | 1 | A payload dword is available |
| pl_data | input | 32 | Payload dword at the head of the queue |
| pl_last | input | 1 | Head dword is the last of its frame |
| pl_pop | output | 1 | Head dword consumed this cycle |
| rx_prim | input | 4 | Kind code of the primitive received from the far end |
| tx_kind | output | 4 | Kind of the transmitted dword (0 data, else primitive) |
| tx_dword | output | 32 | Transmitted data word, zero for primitives |
| done | output | 1 | One-cycle frame completion pulse |
| done_ok | output | 1 | With done: far end reported good reception |
| done_trunc | output | 1 | With done: frame was cut at the length limit |

## Verification
The bench targets the moments when several conditions meet. It sends HOLD from the far end while the upstream queue is also stalled. A design with the wrong priority would send HOLD instead of HOLDA. It raises DMAT in the middle of a frame. A design that misses it keeps sending payload, or one that takes the CRC a cycle late would fold an extra dword into it. It also sends payloads of exactly the limit and of one dword more. A wrong bound would cut a legal frame, or let an oversize one through, or forget to drain the remainder, which would then leak into the next frame.

// File: rtl/frame_tx_link.sv
module frame_tx_link #(
  parameter int          MAX_DW   = 2064,
  parameter logic [31:0] CRC_SEED = 32'h52325032,
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pl_valid,
  input  logic [31:0] pl_data,
  input  logic        pl_last,
  output logic        pl_pop,
  input  logic [3:0]  rx_prim,
  output logic [3:0]  tx_kind,
  output logic [31:0] tx_dword,
  output logic        done,
  output logic        done_ok,
  output logic        done_trunc
);
  localparam int CW = $clog2(MAX_DW + 1);
  localparam logic [3:0] K_DATA = 4'd0, K_SYNC = 4'd1, K_XRDY = 4'd2, K_RRDY = 4'd3,
                         K_SOF = 4'd4, K_EOF = 4'd5, K_HOLD = 4'd6, K_HOLDA = 4'd7,
                         K_DMAT = 4'd8, K_WTRM = 4'd9, K_ROK = 4'd10, K_RERR = 4'd11;

  typedef enum logic [2:0] {S_IDLE, S_XRDY, S_SOF, S_DATA, S_CRC, S_EOF, S_WTRM, S_DROP} st_t;

  st_t st, st_d;
  logic [31:0] crc, crc_d;
  logic [CW-1:0] cnt, cnt_d;
  logic skip, skip_d, trunc, trunc_d;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  always_comb begin
    st_d     = st;
    crc_d    = crc;
    cnt_d    = cnt;
    skip_d   = skip;
    trunc_d  = trunc;
    tx_kind  = K_SYNC;
    tx_dword = '0;
    pl_pop   = 1'b0;
    done     = 1'b0;
    done_ok  = 1'b0;
    case (st)
      S_IDLE: if (pl_valid) st_d = S_XRDY;
      S_XRDY: begin
        tx_kind = K_XRDY;
        if (rx_prim == K_RRDY) st_d = S_SOF;
      end
      S_SOF: begin
        tx_kind = K_SOF;
        crc_d   = CRC_SEED;
        cnt_d   = '0;
        skip_d  = 1'b0;
        trunc_d = 1'b0;
        st_d    = S_DATA;
      end
      S_DATA: begin
        if (rx_prim == K_DMAT) begin
          tx_kind  = K_DATA;
          tx_dword = crc;
          skip_d   = 1'b1;
          st_d     = S_EOF;
        end else if (rx_prim == K_HOLD) begin
          tx_kind = K_HOLDA;
        end else if (!pl_valid) begin
          tx_kind = K_HOLD;
        end else begin
          tx_kind  = K_DATA;
          tx_dword = pl_data;
          pl_pop   = 1'b1;
          crc_d    = crc_step(crc, pl_data);
          cnt_d    = cnt + CW'(1);
          if (pl_last) begin
            st_d = S_CRC;
          end else if (cnt == CW'(MAX_DW - 2)) begin
            st_d    = S_CRC;
            skip_d  = 1'b1;
            trunc_d = 1'b1;
          end
        end
      end
      S_CRC: begin
        tx_kind  = K_DATA;
        tx_dword = crc;
        st_d     = S_EOF;
      end
      S_EOF: begin
        tx_kind = K_EOF;
        st_d    = S_WTRM;
      end
      S_WTRM: begin
        tx_kind = K_WTRM;
        if (rx_prim == K_ROK || rx_prim == K_RERR) begin
          done    = 1'b1;
          done_ok = (rx_prim == K_ROK);
          st_d    = skip ? S_DROP : S_IDLE;
        end
      end
      S_DROP: begin
        pl_pop = pl_valid;
        if (pl_valid && pl_last) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  assign done_trunc = done & trunc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      crc   <= CRC_SEED;
      cnt   <= '0;
      skip  <= 1'b0;
      trunc <= 1'b0;
    end else begin
      st    <= st_d;
      crc   <= crc_d;
      cnt   <= cnt_d;
      skip  <= skip_d;
      trunc <= trunc_d;
    end
  end
endmodule

// File: rtl/frame_tx_link_chk.sv
module frame_tx_link_chk #(
  parameter int MAX_DW = 2064,
  localparam int CW = $clog2(MAX_DW + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    rx_prim,
  input logic [3:0]    tx_kind,
  input logic          pl_pop,
  input logic          done,
  input logic [CW-1:0] cnt
);
  AST_POP_ONLY_DATA_OR_SYNC: assert property (@(posedge clk) disable iff (!rst_n) pl_pop |-> (tx_kind == 4'd0 || tx_kind == 4'd1)); // R3
  AST_SOF_AFTER_RRDY: assert property (@(posedge clk) disable iff (!rst_n) (tx_kind == 4'd2 && rx_prim == 4'd3) |=> tx_kind == 4'd4); // R2
  AST_NO_POP_IN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n) (tx_kind == 4'd6 || tx_kind == 4'd7) |-> !pl_pop); // R4
  AST_HOLDA_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (tx_kind == 4'd7) |-> rx_prim == 4'd6); // R5
  AST_EOF_AFTER_CRC: assert property (@(posedge clk) disable iff (!rst_n) (tx_kind == 4'd5) |-> $past(tx_kind) == 4'd0); // R6
  AST_WTRM_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n) (tx_kind == 4'd5) |=> tx_kind == 4'd9); // R8
  AST_DONE_ON_STATUS: assert property (@(posedge clk) disable iff (!rst_n) done |-> (tx_kind == 4'd9 && (rx_prim == 4'd10 || rx_prim == 4'd11))); // R8
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(MAX_DW - 1)); // R9
endmodule

bind frame_tx_link frame_tx_link_chk #(.MAX_DW(MAX_DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_prim(rx_prim), .tx_kind(tx_kind),
  .pl_pop(pl_pop), .done(done), .cnt(cnt)
);

// File: tb/sim_frame_tx_link.sv
`timescale 1ns/1ps
module sim_frame_tx_link;
  localparam int MAXD = 6;
  localparam int M_IDLE = 0, M_XRDY = 1, M_SOF = 2, M_DATA = 3, M_CRC = 4, M_EOF = 5, M_WTRM = 6, M_DROP = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pl_valid = 1'b0, pl_last = 1'b0, pl_pop;
  logic [31:0] pl_data = '0, tx_dword;
  logic [3:0] rx_prim = '0, tx_kind;
  logic done, done_ok, done_trunc;

  frame_tx_link #(.MAX_DW(MAXD)) u0 (
    .clk(clk), .rst_n(rst_n), .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last),
    .pl_pop(pl_pop), .rx_prim(rx_prim), .tx_kind(tx_kind), .tx_dword(tx_dword),
    .done(done), .done_ok(done_ok), .done_trunc(done_trunc)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  logic [32:0] q[$];
  int m_st, m_cnt, m_wait, hold_left;
  logic [31:0] m_crc;
  bit m_skip, m_trunc, pend_pop, dmat_used;
  int k_rdly, k_smod, k_hat, k_dat, k_sdly;
  bit k_err;
  int n_done; bit got_ok, got_trunc;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R8 watchdog expired act hung exp finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] d);
    for (int i = 31; i >= 0; i--) begin
      bit fb = c[31] ^ d[i];
      c = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      1: return "R1";   2: return "R2";   4: return "R2";
      0: return "R3";   6: return "R4";   7: return "R5";
      5: return "R6";   9: return "R8";   default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s cycle %0d act %0h exp %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step();
    int e_kind; logic [31:0] e_dw; bit e_pop, e_done, e_ok, e_tr;
    int n_st; string tg;
    @(posedge clk); #1;
    if (pend_pop) void'(q.pop_front());
    pend_pop = 0;
    pl_valid = (q.size() > 0) && !(k_smod > 0 && (cyc % k_smod) == 0);
    pl_data  = q.size() > 0 ? q[0][31:0] : 32'h0;
    pl_last  = q.size() > 0 ? q[0][32] : 1'b0;
    rx_prim = 4'd0;
    if (m_st == M_XRDY) rx_prim = (m_wait >= k_rdly) ? 4'd3 : 4'd1;
    else if (m_st == M_DATA) begin
      if (k_dat >= 0 && m_cnt == k_dat && !dmat_used) begin rx_prim = 4'd8; dmat_used = 1; end
      else if (k_hat >= 0 && m_cnt == k_hat && hold_left > 0) begin rx_prim = 4'd6; hold_left--; end
    end else if (m_st == M_WTRM && m_wait >= k_sdly) rx_prim = k_err ? 4'd11 : 4'd10;
    #3;
    e_kind = 1; e_dw = 0; e_pop = 0; e_done = 0; e_ok = 0; n_st = m_st;
    case (m_st)
      M_IDLE: if (pl_valid) n_st = M_XRDY;
      M_XRDY: begin e_kind = 2; if (rx_prim == 3) n_st = M_SOF; end
      M_SOF:  begin e_kind = 4; m_crc = 32'h52325032; m_cnt = 0; m_skip = 0; m_trunc = 0; n_st = M_DATA; end
      M_DATA: begin
        if (rx_prim == 8) begin e_kind = 0; e_dw = m_crc; m_skip = 1; n_st = M_EOF; end
        else if (rx_prim == 6) e_kind = 7;
        else if (!pl_valid) e_kind = 6;
        else begin
          e_kind = 0; e_dw = pl_data; e_pop = 1; m_crc = crc_ref(m_crc, pl_data); m_cnt++;
          if (pl_last) n_st = M_CRC;
          else if (m_cnt == MAXD - 1) begin n_st = M_CRC; m_skip = 1; m_trunc = 1; end
        end
      end
      M_CRC: begin e_kind = 0; e_dw = m_crc; n_st = M_EOF; end
      M_EOF: begin e_kind = 5; n_st = M_WTRM; end
      M_WTRM: begin
        e_kind = 9;
        if (rx_prim == 10 || rx_prim == 11) begin
          e_done = 1; e_ok = (rx_prim == 10); n_st = m_skip ? M_DROP : M_IDLE;
        end
      end
      default: begin e_pop = pl_valid; if (pl_valid && pl_last) n_st = M_IDLE; end
    endcase
    e_tr = e_done & m_trunc;
    tg = e_done ? "R8" : (m_st == M_DROP ? "R10" : tag_of(e_kind));
    check(tx_kind == 4'(e_kind) && tx_dword == e_dw && pl_pop == e_pop && done == e_done
          && done_ok == e_ok && done_trunc == e_tr, tg, "kind/dword/pop/done",
          {tx_kind, tx_dword, pl_pop, done, done_ok, done_trunc},
          {4'(e_kind), e_dw, e_pop, e_done, e_ok, e_tr});
    if (done) begin n_done++; got_ok = done_ok; got_trunc = done_trunc; end
    pend_pop = e_pop;
    m_wait = (n_st == m_st) ? m_wait + 1 : 0;
    m_st = n_st;
  endtask

  task automatic run_frame(input int n, input int rdly, input int smod, input int hat, input int hlen,
                           input int dat, input bit err, input bit exp_trunc, input int seed);
    int guard = 0;
    k_rdly = rdly; k_smod = smod; k_hat = hat; hold_left = hlen; k_dat = dat; k_err = err; k_sdly = 2;
    dmat_used = 0; n_done = 0; got_ok = 0; got_trunc = 0;
    for (int i = 0; i < n; i++)
      q.push_back({(i == n - 1), (i == 0) ? {24'(seed * 7919), 8'h46} : 32'(seed * 32'h9E3779B1 + i * 32'h01234567)});
    do begin step(); guard++; end
    while (guard < 400 && !(n_done > 0 && m_st == M_IDLE && q.size() == 0 && !pend_pop));
    step();
    check(n_done == 1, "R8", "done pulses", n_done, 1);
    check(got_ok == !err, "R8", "done_ok", got_ok, !err);
    check(got_trunc == exp_trunc, "R9", "done_trunc", got_trunc, exp_trunc);
    check(q.size() == 0 && !pend_pop, "R10", "queue drained", q.size(), 0);
  endtask

  initial begin
    m_st = M_IDLE; m_cnt = 0; m_wait = 0; m_crc = 32'h52325032; m_skip = 0; m_trunc = 0; pend_pop = 0;
    k_rdly = 0; k_smod = 0; k_hat = -1; k_dat = -1; k_err = 0; k_sdly = 2; hold_left = 0;
    repeat (3) @(posedge clk);
    #4;
    check(tx_kind == 4'd1 && !pl_pop && !done, "R1", "reset outputs", tx_kind, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) step();
    check(tx_kind == 4'd1, "R1", "idle sync", tx_kind, 1);
    run_frame(3, 0, 0, -1, 0, -1, 0, 0, 1);
    run_frame(4, 3, 3, -1, 0, -1, 1, 0, 2);
    run_frame(5, 1, 3, 1, 3, -1, 0, 0, 3);
    run_frame(5, 0, 0, -1, 0, 2, 0, 0, 4);
    run_frame(8, 0, 0, -1, 0, -1, 0, 1, 5);
    run_frame(5, 2, 0, 4, 2, -1, 1, 0, 6);
    run_frame(6, 0, 4, -1, 0, -1, 0, 1, 7);
    run_frame(1, 0, 0, -1, 0, 0, 0, 0, 8);
    run_frame(1, 1, 0, -1, 0, -1, 0, 0, 9);
    repeat (3) step();
    check(tx_kind == 4'd1 && !pl_pop, "R1", "idle after frames", tx_kind, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule